// File: doc/BRIEF.md
# Audio Sample FIFO with Frame-Position Tagging

This block is a single-channel sample buffer placed between a DMA engine's byte stream and an audio peripheral's word stream. It is built for one direction. In the transmit build, bytes arrive from the memory side and leave as whole words toward the peripheral. In the receive build, words arrive from the peripheral and leave as single bytes toward memory. Each word that crosses the peripheral side carries its slot index within the current audio frame, together with the configured width code. Both of these are sideband signals, outside the data.

Two configuration words control the block. The format word selects the sample width and the number of words per frame. The control word sets an occupancy cap in bytes and a request threshold in bytes. The request output asks the memory side to refill the buffer (transmit) or to drain it (receive). The storage is byte-granular, so any of the three widths shares the same buffer.

Top module: `audio_sample_fifo`

## Requirements
- R1: The format word (config address 0) carries a width code in bits [1:0]: 0 means 1-byte words, 1 means 2-byte words, 2 or 3 means 4-byte words. per_width_o shows the stored code. In transmit, the first byte received lands in bits [7:0] of per_data_o, and any bytes above the word width are zero.
- R2: In the format word, bit 5 selects 4-word frames and bit 4 alone selects 2-word frames. Bit 5 wins if both are set. If neither is set, a frame is 1 word. per_slot_o starts at 0, steps by one on each word that crosses the peripheral side, and returns to 0 after frame length minus one.
- R3: Transmit: mem_ready_o is high only while occupancy is below min(limit, depth). A byte offered while mem_ready_o is low is not stored.
- R4: Transmit: req_o is high exactly while occupancy is at or below the threshold.
- R5: Receive: req_o is high exactly while occupancy is at or above the threshold.
- R6: Receive: per_ready_o is high only while occupancy plus word bytes is at or below the limit. An accepted word contributes only its low word-width bytes, low byte first; its upper bits are discarded. The memory side delivers one byte per handshake, in arrival order.
- R7: Transmit: per_valid_o is high while occupancy is at least the word width in bytes. Each accepted word removes that many bytes.
- R8: Any configuration write returns the slot counter to 0 on the next cycle. This takes precedence over a word transfer in the same cycle, and that transfer still takes place.
- R9: A push and a pop in the same cycle both take effect.
- R10: After reset the buffer is empty, the format is 1-byte words with 1-word frames, the limit is 0x30 and the threshold is 0x18.
- R11: The control word (config address 1) holds the limit in bits [31:16] and the threshold in bits [15:0].

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_addr_i | input | 1 | 0 selects the format word, 1 selects the control word |
| cfg_wdata_i | input | 32 | Configuration write data |
| mem_valid_i | input | 1 | Transmit: memory byte valid |
| mem_data_i | input | 8 | Transmit: memory byte |
| mem_ready_o | output | 1 | Transmit: buffer accepts a byte |
| mem_valid_o | output | 1 | Receive: byte available for memory |
| mem_data_o | output | 8 | Receive: oldest stored byte |
| mem_ready_i | input | 1 | Receive: memory side takes the byte |
| per_valid_o | output | 1 | Transmit: word available for the peripheral |
| per_data_o | output | 32 | Transmit: word toward the peripheral |
| per_ready_i | input | 1 | Transmit: peripheral takes the word |
| per_valid_i | input | 1 | Receive: peripheral word valid |
| per_data_i | input | 32 | Receive: peripheral word |
| per_ready_o | output | 1 | Receive: buffer accepts a word |
| per_slot_o | output | 2 | Slot index in the frame for the current peripheral word |
| per_width_o | output | 2 | Configured width code |
| req_o | output | 1 | Refill request (transmit) or drain request (receive) |

## Verification
Two pairs of events can land in the same cycle. The first pair is a byte entering on one side while a word leaves on the other. The bench provokes this on both builds with a full handshake on each side in a single cycle. It then checks that the following word or byte continues the stream in order, and that the valid flags match the combined occupancy. The second pair is a configuration write arriving together with a peripheral word transfer. Here the bench checks that the slot reads 0 afterwards and that the next word is the one after the transferred word.

// File: rtl/audio_fifo_pkg.sv
`timescale 1ns/1ps
package audio_fifo_pkg;
  localparam int unsigned MAX_WORD_BYTES = 4;
  localparam int unsigned FRAME2_BIT     = 4;
  localparam int unsigned FRAME4_BIT     = 5;

  typedef enum logic [1:0] {
    WCODE_8   = 2'd0,
    WCODE_16  = 2'd1,
    WCODE_32  = 2'd2,
    WCODE_32B = 2'd3
  } wcode_e;

  typedef struct packed {
    logic [15:0] limit;
    logic [15:0] thresh;
  } fifo_ctl_t;

  function automatic logic [2:0] wcode_bytes(input wcode_e code);
    case (code)
      WCODE_8:  return 3'd1;
      WCODE_16: return 3'd2;
      default:  return 3'd4;
    endcase
  endfunction

  function automatic logic [2:0] frame_words(input logic f2, input logic f4);
    if (f4) return 3'd4;
    if (f2) return 3'd2;
    return 3'd1;
  endfunction
endpackage

// File: rtl/audio_fifo_cfg.sv
`timescale 1ns/1ps
module audio_fifo_cfg
  import audio_fifo_pkg::*;
#(
  parameter logic [15:0] RST_LIMIT  = 16'h0030,
  parameter logic [15:0] RST_THRESH = 16'h0018
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        we_i,
  input  logic        addr_i,
  input  logic [31:0] wdata_i,
  output wcode_e      wcode_o,
  output logic [2:0]  wbytes_o,
  output logic [2:0]  frame_len_o,
  output logic [15:0] limit_o,
  output logic [15:0] thresh_o
);
  wcode_e    wcode_q;
  logic      f2_q, f4_q;
  fifo_ctl_t ctl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wcode_q <= WCODE_8;
      f2_q    <= 1'b0;
      f4_q    <= 1'b0;
      ctl_q   <= '{limit: RST_LIMIT, thresh: RST_THRESH};
    end else if (we_i) begin
      if (!addr_i) begin
        wcode_q <= wcode_e'(wdata_i[1:0]);
        f2_q    <= wdata_i[FRAME2_BIT];
        f4_q    <= wdata_i[FRAME4_BIT];
      end else begin
        ctl_q <= fifo_ctl_t'(wdata_i);
      end
    end
  end

  assign wcode_o     = wcode_q;
  assign wbytes_o    = wcode_bytes(wcode_q);
  assign frame_len_o = frame_words(f2_q, f4_q);
  assign limit_o     = ctl_q.limit;
  assign thresh_o    = ctl_q.thresh;
endmodule

// File: rtl/audio_fifo_store.sv
`timescale 1ns/1ps
module audio_fifo_store
  import audio_fifo_pkg::*;
#(
  parameter int unsigned DEPTH_LOG2 = 8,
  localparam int unsigned DEPTH = 1 << DEPTH_LOG2,
  localparam int unsigned PW    = DEPTH_LOG2,
  localparam int unsigned CW    = DEPTH_LOG2 + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [2:0]    push_n_i,
  input  logic [31:0]   push_data_i,
  input  logic [2:0]    pop_n_i,
  output logic [31:0]   head_o,
  output logic [CW-1:0] count_o
);
  logic [7:0]    mem_q [DEPTH];
  logic [PW-1:0] wr_q, rd_q;
  logic [CW-1:0] count_q;

  always_ff @(posedge clk_i) begin
    for (int i = 0; i < MAX_WORD_BYTES; i++) begin
      if (3'(i) < push_n_i) mem_q[wr_q + PW'(i)] <= push_data_i[8*i +: 8];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q    <= '0;
      rd_q    <= '0;
      count_q <= '0;
    end else begin
      wr_q    <= wr_q + PW'(push_n_i);
      rd_q    <= rd_q + PW'(pop_n_i);
      count_q <= count_q + CW'(push_n_i) - CW'(pop_n_i);
    end
  end

  always_comb begin
    for (int i = 0; i < MAX_WORD_BYTES; i++) head_o[8*i +: 8] = mem_q[rd_q + PW'(i)];
  end

  assign count_o = count_q;

  AST_NO_UNDERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    CW'(pop_n_i) <= count_q); // R7
  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    32'(count_q) + 32'(push_n_i) <= 32'(DEPTH) + 32'(pop_n_i)); // R3
endmodule

// File: rtl/audio_fifo_slot.sv
`timescale 1ns/1ps
module audio_fifo_slot (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       restart_i,
  input  logic       adv_i,
  input  logic [2:0] frame_len_i,
  output logic [1:0] slot_o
);
  logic [1:0] slot_q;
  logic [2:0] nxt;

  assign nxt = {1'b0, slot_q} + 3'd1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        slot_q <= '0;
    else if (restart_i) slot_q <= '0;  // config write outranks advance
    else if (adv_i)     slot_q <= (nxt >= frame_len_i) ? 2'd0 : nxt[1:0];
  end

  assign slot_o = slot_q;

  AST_SLOT_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    {1'b0, slot_q} < frame_len_i); // R2
  AST_SLOT_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_i |=> (slot_q == 2'd0)); // R8
endmodule

// File: rtl/audio_sample_fifo.sv
`timescale 1ns/1ps
module audio_sample_fifo
  import audio_fifo_pkg::*;
#(
  parameter int unsigned DEPTH_LOG2 = 8,
  parameter bit          IS_TX      = 1'b1,
  parameter logic [15:0] RST_LIMIT  = 16'h0030,
  parameter logic [15:0] RST_THRESH = 16'h0018
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        cfg_we_i,
  input  logic        cfg_addr_i,
  input  logic [31:0] cfg_wdata_i,
  input  logic        mem_valid_i,
  input  logic [7:0]  mem_data_i,
  output logic        mem_ready_o,
  output logic        mem_valid_o,
  output logic [7:0]  mem_data_o,
  input  logic        mem_ready_i,
  output logic        per_valid_o,
  output logic [31:0] per_data_o,
  input  logic        per_ready_i,
  input  logic        per_valid_i,
  input  logic [31:0] per_data_i,
  output logic        per_ready_o,
  output logic [1:0]  per_slot_o,
  output logic [1:0]  per_width_o,
  output logic        req_o
);
  localparam int unsigned DEPTH = 1 << DEPTH_LOG2;
  localparam int unsigned CW    = DEPTH_LOG2 + 1;

  wcode_e        wcode;
  logic [2:0]    wbytes, frame_len, push_n, pop_n;
  logic [15:0]   limit, thresh;
  logic [31:0]   push_data, head, occ, lim_eff;
  logic [CW-1:0] count;
  logic          adv;

  audio_fifo_cfg #(.RST_LIMIT(RST_LIMIT), .RST_THRESH(RST_THRESH)) u_cfg (
    .clk_i, .rst_ni, .we_i(cfg_we_i), .addr_i(cfg_addr_i), .wdata_i(cfg_wdata_i),
    .wcode_o(wcode), .wbytes_o(wbytes), .frame_len_o(frame_len),
    .limit_o(limit), .thresh_o(thresh)
  );

  audio_fifo_store #(.DEPTH_LOG2(DEPTH_LOG2)) u_store (
    .clk_i, .rst_ni, .push_n_i(push_n), .push_data_i(push_data),
    .pop_n_i(pop_n), .head_o(head), .count_o(count)
  );

  audio_fifo_slot u_slot (
    .clk_i, .rst_ni, .restart_i(cfg_we_i), .adv_i(adv),
    .frame_len_i(frame_len), .slot_o(per_slot_o)
  );

  assign occ         = 32'(count);
  assign lim_eff     = ({16'b0, limit} > 32'(DEPTH)) ? 32'(DEPTH) : {16'b0, limit};
  assign per_width_o = wcode;

  if (IS_TX) begin : g_tx
    logic pop;
    logic unused_rx;
    assign mem_ready_o = occ < lim_eff;
    assign per_valid_o = occ >= 32'(wbytes);
    assign pop         = per_valid_o & per_ready_i;
    assign push_n      = (mem_valid_i & mem_ready_o) ? 3'd1 : 3'd0;
    assign push_data   = {24'b0, mem_data_i};
    assign pop_n       = pop ? wbytes : 3'd0;
    assign adv         = pop;
    assign req_o       = occ <= {16'b0, thresh};
    assign mem_valid_o = 1'b0;
    assign mem_data_o  = 8'h00;
    assign per_ready_o = 1'b0;
    assign unused_rx   = ^{mem_ready_i, per_valid_i, per_data_i};

    always_comb begin
      for (int i = 0; i < MAX_WORD_BYTES; i++)
        per_data_o[8*i +: 8] = (3'(i) < wbytes) ? head[8*i +: 8] : 8'h00;
    end

    AST_TX_LIMIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (occ >= lim_eff) |=> (occ <= $past(occ))); // R3
    AST_TX_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (per_valid_o && !per_ready_i && !cfg_we_i) |=> per_valid_o); // R7
  end else begin : g_rx
    logic push;
    logic unused_tx;
    assign per_ready_o = occ + 32'(wbytes) <= lim_eff;
    assign push        = per_valid_i & per_ready_o;
    assign push_n      = push ? wbytes : 3'd0;
    assign push_data   = per_data_i;
    assign mem_valid_o = occ != 32'd0;
    assign mem_data_o  = head[7:0];
    assign pop_n       = (mem_valid_o & mem_ready_i) ? 3'd1 : 3'd0;
    assign adv         = push;
    assign req_o       = occ >= {16'b0, thresh};
    assign mem_ready_o = 1'b0;
    assign per_valid_o = 1'b0;
    assign per_data_o  = 32'h0;
    assign unused_tx   = ^{mem_valid_i, mem_data_i, per_ready_i, head[31:8]};

    AST_RX_LIMIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (occ >= lim_eff) |=> (occ <= $past(occ))); // R6
    AST_RX_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mem_valid_o && !mem_ready_i) |=> mem_valid_o); // R6
  end
endmodule

// File: tb/audio_sample_fifo_tb.sv
`timescale 1ns/1ps
module audio_sample_fifo_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // transmit build
  logic t_we = 0, t_addr = 0, t_mv_i = 0, t_mr_i = 0, t_pr_i = 0, t_pv_i = 0;
  logic [31:0] t_wd = 0, t_pd_i = 0;
  logic [7:0] t_md_i = 0;
  logic t_mr_o, t_mv_o, t_pv_o, t_pr_o, t_req;
  logic [7:0] t_md_o;
  logic [31:0] t_pd_o;
  logic [1:0] t_slot, t_wid;

  // receive build
  logic r_we = 0, r_addr = 0, r_mv_i = 0, r_mr_i = 0, r_pr_i = 0, r_pv_i = 0;
  logic [31:0] r_wd = 0, r_pd_i = 0;
  logic [7:0] r_md_i = 0;
  logic r_mr_o, r_mv_o, r_pv_o, r_pr_o, r_req;
  logic [7:0] r_md_o;
  logic [31:0] r_pd_o;
  logic [1:0] r_slot, r_wid;

  audio_sample_fifo #(.IS_TX(1'b1)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(t_we), .cfg_addr_i(t_addr), .cfg_wdata_i(t_wd),
    .mem_valid_i(t_mv_i), .mem_data_i(t_md_i), .mem_ready_o(t_mr_o),
    .mem_valid_o(t_mv_o), .mem_data_o(t_md_o), .mem_ready_i(t_mr_i),
    .per_valid_o(t_pv_o), .per_data_o(t_pd_o), .per_ready_i(t_pr_i),
    .per_valid_i(t_pv_i), .per_data_i(t_pd_i), .per_ready_o(t_pr_o),
    .per_slot_o(t_slot), .per_width_o(t_wid), .req_o(t_req)
  );

  audio_sample_fifo #(.IS_TX(1'b0)) u_dut_rx (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(r_we), .cfg_addr_i(r_addr), .cfg_wdata_i(r_wd),
    .mem_valid_i(r_mv_i), .mem_data_i(r_md_i), .mem_ready_o(r_mr_o),
    .mem_valid_o(r_mv_o), .mem_data_o(r_md_o), .mem_ready_i(r_mr_i),
    .per_valid_o(r_pv_o), .per_data_o(r_pd_o), .per_ready_i(r_pr_i),
    .per_valid_i(r_pv_i), .per_data_i(r_pd_i), .per_ready_o(r_pr_o),
    .per_slot_o(r_slot), .per_width_o(r_wid), .req_o(r_req)
  );

  function automatic logic [7:0] bv(input int s, input int k);
    return 8'(s * 37 + k * 5 + 1);
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic t_cfg(input logic a, input logic [31:0] d);
    t_we = 1; t_addr = a; t_wd = d; tick(); t_we = 0;
  endtask

  task automatic r_cfg(input logic a, input logic [31:0] d);
    r_we = 1; r_addr = a; r_wd = d; tick(); r_we = 0;
  endtask

  task automatic t_push(input logic [7:0] b);
    t_mv_i = 1; t_md_i = b; tick(); t_mv_i = 0;
  endtask

  task automatic t_pop(output logic [31:0] d, output logic [1:0] s);
    d = t_pd_o; s = t_slot; t_pr_i = 1; tick(); t_pr_i = 0;
  endtask

  task automatic r_push(input logic [31:0] w);
    r_pv_i = 1; r_pd_i = w; tick(); r_pv_i = 0;
  endtask

  task automatic r_popb(output logic [7:0] d);
    d = r_md_o; r_mr_i = 1; tick(); r_mr_i = 0;
  endtask

  initial begin
    logic [31:0] d, exp;
    logic [1:0] sl;
    logic [7:0] b;
    int cnt;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    tick();

    // reset state
    check("R10 tx ready", t_mr_o, 1);
    check("R10 tx valid", t_pv_o, 0);
    check("R10 tx req", t_req, 1);
    check("R10 tx slot", t_slot, 0);
    check("R10 tx width", t_wid, 0);
    check("R10 rx valid", r_mv_o, 0);
    check("R10 rx ready", r_pr_o, 1);
    check("R10 rx req", r_req, 0);

    // default limit 0x30, threshold 0x18
    for (int k = 0; k < 50; k++) begin
      cnt = (k < 48) ? k : 48;
      check("R10 R3 tx ready at default limit", t_mr_o, (cnt < 48) ? 1 : 0);
      check("R10 R4 tx req at default threshold", t_req, (cnt <= 24) ? 1 : 0);
      t_push((k < 48) ? 8'(k) : 8'hEE);
    end
    for (int k = 0; k < 48; k++) begin
      check("R7 tx valid", t_pv_o, 1);
      t_pop(d, sl);
      check("R3 tx data, rejected bytes absent", d, 32'(k));
    end
    check("R7 tx empty", t_pv_o, 0);

    // width and frame sweep, transmit
    for (int w = 0; w < 4; w++) begin
      for (int f = 0; f < 4; f++) begin
        int s, wb, fl;
        s = w * 4 + f;
        wb = (w == 0) ? 1 : (w == 1) ? 2 : 4;
        fl = (f >= 2) ? 4 : (f == 1) ? 2 : 1;
        t_cfg(0, 32'(f << 4) | 32'(w));
        t_cfg(1, {16'(48 * wb), 16'(24 * wb)});
        check("R1 tx width code", t_wid, 32'(w));
        check("R8 tx slot after cfg", t_slot, 0);
        for (int k = 0; k < 6 * wb; k++) t_push(bv(s, k));
        for (int j = 0; j < 6; j++) begin
          exp = 0;
          for (int i = 0; i < wb; i++) exp[8*i +: 8] = bv(s, j * wb + i);
          check("R7 tx word valid", t_pv_o, 1);
          t_pop(d, sl);
          check("R1 tx word data", d, exp);
          check("R2 tx slot", sl, 32'(j % fl));
        end
        check("R7 tx drained", t_pv_o, 0);
      end
    end

    // control field positions, limit and threshold, transmit
    t_cfg(0, 32'h0);
    t_cfg(1, {16'd10, 16'd3});
    for (int k = 0; k < 12; k++) begin
      cnt = (k < 10) ? k : 10;
      check("R11 R3 tx ready vs limit", t_mr_o, (cnt < 10) ? 1 : 0);
      check("R11 R4 tx req vs threshold", t_req, (cnt <= 3) ? 1 : 0);
      t_push(bv(99, k));
    end
    for (int k = 0; k < 10; k++) begin
      t_pop(d, sl);
      check("R3 tx data under custom limit", d, 32'(bv(99, k)));
    end
    check("R3 tx over-limit bytes dropped", t_pv_o, 0);
    check("R4 tx req when empty", t_req, 1);

    // push and pop in the same cycle, transmit, 16-bit
    t_cfg(0, 32'h1);
    t_cfg(1, {16'h60, 16'h30});
    for (int k = 0; k < 4; k++) t_push(bv(50, k));
    check("R9 tx first word", t_pd_o, {16'h0, bv(50, 1), bv(50, 0)});
    t_mv_i = 1; t_md_i = bv(50, 4); t_pr_i = 1;
    tick();
    t_mv_i = 0; t_pr_i = 0;
    check("R9 tx valid after overlap", t_pv_o, 1);
    check("R9 tx word after overlap", t_pd_o, {16'h0, bv(50, 3), bv(50, 2)});
    t_pop(d, sl);
    check("R9 tx one byte left", t_pv_o, 0);
    t_push(bv(50, 5));
    check("R9 tx last word", t_pd_o, {16'h0, bv(50, 5), bv(50, 4)});
    t_pop(d, sl);
    check("R9 tx empty again", t_pv_o, 0);

    // config write colliding with a word transfer
    t_cfg(0, 32'h20);
    for (int k = 0; k < 4; k++) t_push(bv(60, k));
    t_pop(d, sl);
    check("R2 tx slot 0", sl, 0);
    t_pop(d, sl);
    check("R2 tx slot 1", sl, 1);
    check("R2 tx slot 2 pending", t_slot, 2);
    t_pr_i = 1; t_we = 1; t_addr = 0; t_wd = 32'h20;
    tick();
    t_pr_i = 0; t_we = 0;
    check("R8 tx slot restart wins", t_slot, 0);
    check("R8 tx transfer still taken", t_pd_o, 32'(bv(60, 3)));
    t_pop(d, sl);
    check("R8 tx slot resumes", t_slot, 1);

    // width and frame sweep, receive
    for (int w = 0; w < 4; w++) begin
      for (int f = 0; f < 4; f++) begin
        int s, wb, fl;
        s = 16 + w * 4 + f;
        wb = (w == 0) ? 1 : (w == 1) ? 2 : 4;
        fl = (f >= 2) ? 4 : (f == 1) ? 2 : 1;
        r_cfg(0, 32'(f << 4) | 32'(w));
        r_cfg(1, {16'(48 * wb), 16'(24 * wb)});
        check("R1 rx width code", r_wid, 32'(w));
        for (int j = 0; j < 5; j++) begin
          check("R6 rx ready", r_pr_o, 1);
          check("R2 rx slot", r_slot, 32'(j % fl));
          r_push({bv(s, 4*j+3), bv(s, 4*j+2), bv(s, 4*j+1), bv(s, 4*j)});
        end
        check("R2 rx slot after run", r_slot, 32'(5 % fl));
        for (int j = 0; j < 5; j++) begin
          for (int i = 0; i < wb; i++) begin
            check("R6 rx byte valid", r_mv_o, 1);
            r_popb(b);
            check("R6 rx byte order", b, 32'(bv(s, 4*j+i)));
          end
        end
        check("R6 rx upper bytes discarded", r_mv_o, 0);
      end
    end

    // limit and drain request, receive, 16-bit
    r_cfg(0, 32'h1);
    r_cfg(1, {16'd8, 16'd4});
    for (int j = 0; j < 5; j++) begin
      cnt = (2 * j < 8) ? 2 * j : 8;
      check("R6 R11 rx ready vs limit", r_pr_o, (cnt + 2 <= 8) ? 1 : 0);
      check("R5 rx req fill", r_req, (cnt >= 4) ? 1 : 0);
      r_push({bv(70, 4*j+3), bv(70, 4*j+2), bv(70, 4*j+1), bv(70, 4*j)});
    end
    for (int k = 0; k < 8; k++) begin
      check("R5 rx req drain", r_req, ((8 - k) >= 4) ? 1 : 0);
      r_popb(b);
      check("R6 rx data under limit", b, 32'(bv(70, 4 * (k / 2) + (k % 2))));
    end
    check("R6 rx refused word absent", r_mv_o, 0);

    // push and pop in the same cycle, receive
    r_cfg(0, 32'h0);
    r_cfg(1, {16'h30, 16'h18});
    r_push(32'hFFFFFF11);
    check("R9 rx first byte", r_md_o, 32'h11);
    r_pv_i = 1; r_pd_i = 32'hFFFFFF22; r_mr_i = 1;
    tick();
    r_pv_i = 0; r_mr_i = 0;
    check("R9 rx valid after overlap", r_mv_o, 1);
    check("R9 rx byte after overlap", r_md_o, 32'h22);
    r_popb(b);
    check("R9 rx empty again", r_mv_o, 0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #800000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog act=running exp=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule